// File: doc/BRIEF.md
# CHIP-8 Opcode Decoder

This block takes one 16-bit CHIP-8 instruction word and, with no clock, turns it into everything the control sequencer needs before execution starts. It slices the word into nibbles and presents the register indices, the byte immediate, the 12-bit address and the low nibble. It also passes the top nibble through as the primary operation. The clear/return group (top nibble 0), the key-skip group (E) and the timer/memory group (F) are mapped into one dense 4-bit secondary operation space, so the sequencer can dispatch on a small number.

Beside the fields, the decoder tells the sequencer which operands to route to the separate ALU. It also raises a set of flags. One marks instructions that need more than one clock. One marks the indexed jump, which also reads V0. One marks writes to VX, and another marks ALU forms that also update the VF flag. A last flag marks words that have no defined meaning. Because the block is a pure function of 16 bits, every possible word can be checked.

Top module: `chip8_op_decode`

## Requirements
- R1: `x_idx` = opcode[11:8], `y_idx` = opcode[7:4], `n4` = opcode[3:0], `imm8` = opcode[7:0] and `addr12` = opcode[11:0] for every opcode, legal or not.
- R2: `op_major` equals opcode[15:12] for every opcode.
- R3: For legal 0/E/F-group words, `op_minor` is: 00E0→0, 00EE→1, EX9E→2, EXA1→3, FX07→4, FX0A→5, FX15→6, FX18→7, FX1E→8, FX29→9, FX33→10, FX55→11, FX65→12.
- R4: `illegal` is 1 exactly for these words: top nibble 0 other than 00E0/00EE; 5XYn or 9XYn with n≠0; 8XYn with n in 8..D or F; E-group with a low byte other than 9E/A1; F-group with a low byte outside the thirteen forms of R3.
- R5: `multi_cycle` is 1 exactly for DXYN, FX33, FX55 and FX65.
- R6: `uses_v0` is 1 exactly for BNNN.
- R7: `writes_vx` is 1 exactly for 6XNN, 7XNN, the legal 8XYn forms, CXNN, FX07 and FX0A.
- R8: `writes_vf` is 1 exactly for 8XY4, 8XY5, 8XY6, 8XY7 and 8XYE.
- R9: `alu_a_sel` (0 none, 1 VX, 2 V0) and `alu_b_sel` (0 none, 1 VY, 2 NN, 3 NNN) are: 1NNN/2NNN/ANNN → (0,3); BNNN → (2,3); 3XNN/4XNN/7XNN → (1,2); 6XNN/CXNN → (0,2); 5XY0/9XY0/8XYn/DXYN → (1,1); EX9E/EXA1/FX15/FX18/FX1E/FX29/FX33 → (1,0); all other legal words → (0,0).
- R10: When `illegal` is 1, the four flags `multi_cycle`, `uses_v0`, `writes_vx` and `writes_vf` are 0 and both ALU selectors are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 16 | Instruction word |
| op_major | output | 4 | Primary operation (top nibble) |
| op_minor | output | 4 | Secondary operation for 0/E/F groups |
| x_idx | output | 4 | X register index |
| y_idx | output | 4 | Y register index |
| imm8 | output | 8 | Byte immediate NN |
| addr12 | output | 12 | Address immediate NNN |
| n4 | output | 4 | Low nibble N |
| alu_a_sel | output | 2 | ALU operand A source |
| alu_b_sel | output | 2 | ALU operand B source |
| multi_cycle | output | 1 | Needs more than one execute clock |
| uses_v0 | output | 1 | Also reads V0 |
| writes_vx | output | 1 | Writes register VX |
| writes_vf | output | 1 | Also writes the VF flag |
| illegal | output | 1 | Undefined encoding |

## Verification
Two results can be active for the same word. The ALU forms 8XY4 to 8XYE must raise both the VX write and the VF write. An undefined word must raise `illegal` and still deliver correct field slices, while every flag and selector stays quiet. The bench applies all 65,536 words, one per clock. For each word it computes the expected flags, selectors, secondary code and fields arithmetically from the nibbles. It then compares each group separately, so a word that should raise two results is judged on both.

// File: rtl/chip8_op_decode.sv
module chip8_op_decode (
  input  logic [15:0] opcode,
  output logic [3:0]  op_major,
  output logic [3:0]  op_minor,
  output logic [3:0]  x_idx,
  output logic [3:0]  y_idx,
  output logic [7:0]  imm8,
  output logic [11:0] addr12,
  output logic [3:0]  n4,
  output logic [1:0]  alu_a_sel,
  output logic [1:0]  alu_b_sel,
  output logic        multi_cycle,
  output logic        uses_v0,
  output logic        writes_vx,
  output logic        writes_vf,
  output logic        illegal
);
  localparam logic [1:0] A_NONE = 2'd0, A_VX = 2'd1, A_V0 = 2'd2;
  localparam logic [1:0] B_NONE = 2'd0, B_VY = 2'd1, B_NN = 2'd2, B_NNN = 2'd3;

  localparam logic [3:0] M_CLS  = 4'd0,  M_RET  = 4'd1,  M_SKP  = 4'd2,  M_SKNP = 4'd3;
  localparam logic [3:0] M_GDT  = 4'd4,  M_WKEY = 4'd5,  M_SDT  = 4'd6,  M_SST  = 4'd7;
  localparam logic [3:0] M_ADDI = 4'd8,  M_FONT = 4'd9,  M_BCD  = 4'd10, M_STOR = 4'd11;
  localparam logic [3:0] M_LOAD = 4'd12;

  assign op_major = opcode[15:12];
  assign x_idx    = opcode[11:8];
  assign y_idx    = opcode[7:4];
  assign n4       = opcode[3:0];
  assign imm8     = opcode[7:0];
  assign addr12   = opcode[11:0];

  logic       ok, mc, v0, wx, wf;
  logic [1:0] sa, sb;
  logic [3:0] mn;

  always_comb begin
    ok = 1'b1;
    mc = 1'b0;
    v0 = 1'b0;
    wx = 1'b0;
    wf = 1'b0;
    sa = A_NONE;
    sb = B_NONE;
    mn = 4'd0;
    unique case (op_major)
      4'h0: begin
        if (opcode[11:0] == 12'h0E0)      mn = M_CLS;
        else if (opcode[11:0] == 12'h0EE) mn = M_RET;
        else                              ok = 1'b0;
      end
      4'h1, 4'h2, 4'hA: sb = B_NNN;
      4'hB: begin
        sa = A_V0;
        sb = B_NNN;
        v0 = 1'b1;
      end
      4'h3, 4'h4: begin
        sa = A_VX;
        sb = B_NN;
      end
      4'h5, 4'h9: begin
        if (n4 == 4'h0) begin
          sa = A_VX;
          sb = B_VY;
        end else ok = 1'b0;
      end
      4'h6, 4'hC: begin
        sb = B_NN;
        wx = 1'b1;
      end
      4'h7: begin
        sa = A_VX;
        sb = B_NN;
        wx = 1'b1;
      end
      4'h8: begin
        sa = A_VX;
        sb = B_VY;
        case (n4)
          4'h0, 4'h1, 4'h2, 4'h3: wx = 1'b1;
          4'h4, 4'h5, 4'h6, 4'h7, 4'hE: begin
            wx = 1'b1;
            wf = 1'b1;
          end
          default: ok = 1'b0;
        endcase
      end
      4'hD: begin
        sa = A_VX;
        sb = B_VY;
        mc = 1'b1;
      end
      4'hE: begin
        sa = A_VX;
        if (imm8 == 8'h9E)      mn = M_SKP;
        else if (imm8 == 8'hA1) mn = M_SKNP;
        else                    ok = 1'b0;
      end
      default: begin
        case (imm8)
          8'h07: begin mn = M_GDT;  wx = 1'b1; end
          8'h0A: begin mn = M_WKEY; wx = 1'b1; end
          8'h15: begin mn = M_SDT;  sa = A_VX; end
          8'h18: begin mn = M_SST;  sa = A_VX; end
          8'h1E: begin mn = M_ADDI; sa = A_VX; end
          8'h29: begin mn = M_FONT; sa = A_VX; end
          8'h33: begin mn = M_BCD;  sa = A_VX; mc = 1'b1; end
          8'h55: begin mn = M_STOR; mc = 1'b1; end
          8'h65: begin mn = M_LOAD; mc = 1'b1; end
          default: ok = 1'b0;
        endcase
      end
    endcase
  end

  assign illegal     = ~ok;
  assign op_minor    = ok ? mn : 4'd0;
  assign alu_a_sel   = ok ? sa : A_NONE;
  assign alu_b_sel   = ok ? sb : B_NONE;
  assign multi_cycle = ok & mc;
  assign uses_v0     = ok & v0;
  assign writes_vx   = ok & wx;
  assign writes_vf   = ok & wf;
endmodule

// File: rtl/chip8_op_decode_chk.sv
module chip8_op_decode_chk (
  input logic [15:0] opcode,
  input logic [3:0]  op_major,
  input logic [3:0]  x_idx,
  input logic [3:0]  y_idx,
  input logic [7:0]  imm8,
  input logic [11:0] addr12,
  input logic [3:0]  n4,
  input logic [1:0]  alu_a_sel,
  input logic [1:0]  alu_b_sel,
  input logic        multi_cycle,
  input logic        uses_v0,
  input logic        writes_vx,
  input logic        writes_vf,
  input logic        illegal
);
  always_comb begin
    a_r1_field_slices: assert ({x_idx, y_idx, n4} == addr12 && imm8 == opcode[7:0] && addr12 == opcode[11:0]);
    a_r5_multi_is_legal_draw_or_f: assert (!multi_cycle || (!illegal && (op_major == 4'hD || op_major == 4'hF)));
    a_r6_v0_only_indexed_jump: assert (!uses_v0 || (op_major == 4'hB && alu_a_sel == 2'd2));
    a_r8_vf_implies_vx_alu: assert (!writes_vf || (writes_vx && op_major == 4'h8));
    a_r10_illegal_is_quiet: assert (!illegal || ({multi_cycle, uses_v0, writes_vx, writes_vf} == 4'b0 && alu_a_sel == 2'd0 && alu_b_sel == 2'd0));
  end
endmodule

bind chip8_op_decode chip8_op_decode_chk u_chk (.*);

// File: tb/tb_chip8_op_decode.sv
`timescale 1ns/1ps
module tb_chip8_op_decode;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] opcode;
  logic [3:0]  op_major, op_minor, x_idx, y_idx, n4;
  logic [7:0]  imm8;
  logic [11:0] addr12;
  logic [1:0]  alu_a_sel, alu_b_sel;
  logic        multi_cycle, uses_v0, writes_vx, writes_vf, illegal;

  chip8_op_decode dut (.*);

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp, input logic [15:0] op);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s op=%04h actual=%0h expected=%0h", req, op, act, exp);
    end
  endtask

  initial begin
    #(4 * 300000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    opcode = 16'h0000;
    @(negedge clk);
    chk(illegal === 1'b1, "R4 reset word 0000", {31'd0, illegal}, 32'd1, opcode);
    for (int i = 0; i < 65536; i++) begin
      logic [3:0] t, x, y, n;
      logic [7:0] lo;
      int e_min, e_a, e_b;
      bit e_ill, e_mc, e_v0, e_wx, e_wf, grp;
      @(posedge clk);
      opcode = i[15:0];
      @(negedge clk);
      t = i[15:12]; x = i[11:8]; y = i[7:4]; n = i[3:0]; lo = i[7:0];
      e_ill = 0; e_mc = 0; e_v0 = 0; e_wx = 0; e_wf = 0; e_a = 0; e_b = 0; e_min = 0;
      grp = (t == 4'h0 || t == 4'hE || t == 4'hF);
      case (t)
        4'h0: if (i == 16'h00E0) e_min = 0; else if (i == 16'h00EE) e_min = 1; else e_ill = 1;
        4'h1, 4'h2, 4'hA: e_b = 3;
        4'hB: begin e_a = 2; e_b = 3; e_v0 = 1; end
        4'h3, 4'h4: begin e_a = 1; e_b = 2; end
        4'h5, 4'h9: if (n == 0) begin e_a = 1; e_b = 1; end else e_ill = 1;
        4'h6, 4'hC: begin e_b = 2; e_wx = 1; end
        4'h7: begin e_a = 1; e_b = 2; e_wx = 1; end
        4'h8: if (n <= 7 || n == 4'hE) begin
                e_a = 1; e_b = 1; e_wx = 1;
                e_wf = (n >= 4 && n <= 7) || n == 4'hE;
              end else e_ill = 1;
        4'hD: begin e_a = 1; e_b = 1; e_mc = 1; end
        4'hE: begin
          e_a = 1;
          if (lo == 8'h9E) e_min = 2; else if (lo == 8'hA1) e_min = 3; else begin e_ill = 1; e_a = 0; end
        end
        default: begin
          case (lo)
            8'h07: begin e_min = 4; e_wx = 1; end
            8'h0A: begin e_min = 5; e_wx = 1; end
            8'h15: begin e_min = 6; e_a = 1; end
            8'h18: begin e_min = 7; e_a = 1; end
            8'h1E: begin e_min = 8; e_a = 1; end
            8'h29: begin e_min = 9; e_a = 1; end
            8'h33: begin e_min = 10; e_a = 1; e_mc = 1; end
            8'h55: begin e_min = 11; e_mc = 1; end
            8'h65: begin e_min = 12; e_mc = 1; end
            default: e_ill = 1;
          endcase
        end
      endcase
      if (e_ill) begin e_a = 0; e_b = 0; end
      chk(x_idx == x && y_idx == y && n4 == n && imm8 == lo && addr12 == i[11:0], "R1 fields",
          {x_idx, y_idx, n4, imm8, 4'd0}, {x, y, n, lo, 4'd0}, opcode);
      chk(op_major == t, "R2 major", op_major, t, opcode);
      if (grp && !e_ill) chk(op_minor == e_min[3:0], "R3 minor", op_minor, e_min, opcode);
      chk(illegal == e_ill, "R4 illegal", illegal, e_ill, opcode);
      chk(multi_cycle == e_mc, "R5 multi_cycle", multi_cycle, e_mc, opcode);
      chk(uses_v0 == e_v0, "R6 uses_v0", uses_v0, e_v0, opcode);
      chk(writes_vx == e_wx, "R7 writes_vx", writes_vx, e_wx, opcode);
      chk(writes_vf == e_wf, "R8 writes_vf", writes_vf, e_wf, opcode);
      chk(alu_a_sel == e_a[1:0] && alu_b_sel == e_b[1:0], "R9 alu selectors",
          {alu_a_sel, alu_b_sel}, {e_a[1:0], e_b[1:0]}, opcode);
      if (e_ill)
        chk({multi_cycle, uses_v0, writes_vx, writes_vf, alu_a_sel, alu_b_sel} == 8'd0, "R10 illegal quiet",
            {multi_cycle, uses_v0, writes_vx, writes_vf, alu_a_sel, alu_b_sel}, 0, opcode);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule